// File: doc/BRIEF.md
# Integer Register File with Paired Floating-Point Access

This block is the 32 x 32-bit integer register file of an RV32 core whose floating-point instructions take their operands from, and return their results to, the integer registers. It has three combinational read ports and one write port. Each port carries a register index and a 2-bit format code: half, single or double precision. A double-precision operand spans an even/odd register pair and moves as one 64-bit word in a single access. Narrow results are sign-extended into the register rather than boxed.

Register 0 always reads as zero. A double-width access to register 0 yields an all-zero operand on reads and no change on writes, so register 1 is never touched. A double-width access with an odd index is a reserved encoding. It produces zero data or no write, and it raises a per-port flag that is registered on the following clock edge. Format codes: 0 = half, 1 = single, 2 = double, 3 = single (alias).

The write port has a valid qualifier and no ready signal. The file accepts a write in every cycle, so there is no back-pressure: a write presented with `wr_valid` high is committed at the next rising edge. Read ports have no handshake. Each `rd_valid` bit only qualifies the misalignment flag of its port.

Top module: `fpx_regfile`

## Requirements
- R1: While reset is asserted and just after it, every register reads as zero and `misalign_q` is all zero.
- R2: A write with format 1 or 3 and `wr_valid` high stores `wr_data[31:0]` into the indexed register on the rising edge, ignoring `wr_data[63:32]`; writes to index 0 are discarded. A single-format read returns {32'b0, register}.
- R3: A half-format write stores `wr_data[15:0]` in bits 15:0 and copies `wr_data[15]` into bits 31:16. `wr_data[63:16]` has no effect.
- R4: A half-format read returns register bits 15:0 in `rd_data[15:0]` with bits 63:16 zero, whatever the register's upper bits hold.
- R5: A double-format read with an even non-zero index i returns {x[i+1], x[i]}: the lower-numbered register supplies bits 31:0.
- R6: A double-format write with an even non-zero index i stores `wr_data[31:0]` into x[i] and `wr_data[63:32]` into x[i+1] on the same clock edge.
- R7: A double-format read of index 0 returns 64 zero bits. A double-format write to index 0 modifies no register, including register 1.
- R8: A double-format access with an odd index is misaligned. Such a read returns zero, such a write modifies neither register, and the port's bit of `misalign_q` is 1 in the following cycle. Bit p is read port p, qualified by `rd_valid[p]`; bit 3 is the write port, qualified by `wr_valid`.
- R9: Reads are combinational. A read of a register that is being written in the same cycle returns the value from before the write.
- R10: A `misalign_q` bit is 0 in the cycle after its port made no misaligned double access.
- R11: With `wr_valid` low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write qualifier, always accepted |
| wr_idx | input | 5 | Write register index |
| wr_fmt | input | 2 | Write format code |
| wr_data | input | 64 | Write data; narrow formats use the low bits |
| rd_valid | input | 3 | Per read port qualifier for the misalignment flag |
| rd_idx | input | 3x5 | Read register indices |
| rd_fmt | input | 3x2 | Read format codes |
| rd_data | output | 3x64 | Read operands |
| misalign_q | output | 4 | Registered misalignment flags: bits 2:0 read ports, bit 3 write port |

## Verification
Random traffic draws every format code, including the single alias, across all indices, and biases them toward registers 0 to 3. This makes the zero register, register 1 next to it, odd pairs and even pairs meet often, and a reference model separates correct pair handling from off-by-one or swapped-half errors. Directed cycles cover cases the random stream seldom isolates. A half write with junk in the upper data bits shows whether the result is sign-extended or passed through. A pair write followed by single reads of both halves shows the ordering within the pair. A double write to register 0 shows whether register 1 is left alone. An odd pair write shows whether it is suppressed and flagged. A read of a register during its own write shows old-versus-new data, and a write held off by `wr_valid` shows that it has no effect.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  typedef enum logic [1:0] {
    FMT_HALF       = 2'd0,
    FMT_SINGLE     = 2'd1,
    FMT_DOUBLE     = 2'd2,
    FMT_SINGLE_ALT = 2'd3
  } fpx_fmt_e;

  localparam int HALF_W = 16;

  function automatic logic fmt_is_pair(input logic [1:0] f);
    return f == FMT_DOUBLE;
  endfunction

  function automatic logic fmt_is_half(input logic [1:0] f);
    return f == FMT_HALF;
  endfunction

endpackage

// File: rtl/fpx_wr_shape.sv
module fpx_wr_shape
  import fpx_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic              valid,
  input  logic [IDXW-1:0]   idx,
  input  logic [1:0]        fmt,
  input  logic [2*XLEN-1:0] data,
  output logic [NREGS-1:0]  we,
  output logic [NREGS-1:0]  take_hi,
  output logic [XLEN-1:0]   lo_word,
  output logic [XLEN-1:0]   hi_word,
  output logic              misalign
);

  logic pair;
  logic pair_ok;

  always_comb begin
    pair     = fmt_is_pair(fmt);
    misalign = valid && pair && idx[0];
    pair_ok  = valid && pair && !idx[0] && (idx != '0);
    hi_word  = data[2*XLEN-1:XLEN];
    if (fmt_is_half(fmt))
      lo_word = {{(XLEN-HALF_W){data[HALF_W-1]}}, data[HALF_W-1:0]};
    else
      lo_word = data[XLEN-1:0];
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_sel
    localparam logic [IDXW-1:0] RI = IDXW'(r);
    if (r == 0) begin : g_zero
      assign we[r]      = 1'b0;
      assign take_hi[r] = 1'b0;
    end else begin : g_reg
      assign we[r] = pair ? (pair_ok && (idx[IDXW-1:1] == RI[IDXW-1:1]))
                          : (valid && (idx == RI));
      assign take_hi[r] = pair && RI[0];
    end
  end

endmodule

// File: rtl/fpx_rd_port.sv
module fpx_rd_port
  import fpx_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic [NREGS-1:0][XLEN-1:0] file_q,
  input  logic                       valid,
  input  logic [IDXW-1:0]            idx,
  input  logic [1:0]                 fmt,
  output logic [2*XLEN-1:0]          data,
  output logic                       misalign
);

  logic [XLEN-1:0] lo_w;
  logic [XLEN-1:0] hi_w;
  logic [IDXW-1:0] hi_idx;

  always_comb begin
    hi_idx   = {idx[IDXW-1:1], 1'b1};
    lo_w     = file_q[idx];
    hi_w     = file_q[hi_idx];
    misalign = valid && fmt_is_pair(fmt) && idx[0];
    if (fmt_is_pair(fmt)) begin
      if (idx[0] || (idx == '0)) data = '0;
      else                       data = {hi_w, lo_w};
    end else if (fmt_is_half(fmt)) begin
      data = {{(2*XLEN-HALF_W){1'b0}}, lo_w[HALF_W-1:0]};
    end else begin
      data = {{XLEN{1'b0}}, lo_w};
    end
  end

endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_d,
  output logic [NFLAG-1:0] flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/fpx_regfile.sv
module fpx_regfile
  import fpx_pkg::*;
#(
  parameter int  NREGS = 32,
  parameter int  XLEN  = 32,
  parameter int  NRD   = 3,
  localparam int IDXW  = $clog2(NREGS),
  localparam int DW    = 2 * XLEN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [IDXW-1:0]           wr_idx,
  input  logic [1:0]                wr_fmt,
  input  logic [DW-1:0]             wr_data,
  input  logic [NRD-1:0]            rd_valid,
  input  logic [NRD-1:0][IDXW-1:0]  rd_idx,
  input  logic [NRD-1:0][1:0]       rd_fmt,
  output logic [NRD-1:0][DW-1:0]    rd_data,
  output logic [NRD:0]              misalign_q
);

  logic [NREGS-1:0][XLEN-1:0] file_q;
  logic [NREGS-1:0]           we;
  logic [NREGS-1:0]           take_hi;
  logic [XLEN-1:0]            lo_word;
  logic [XLEN-1:0]            hi_word;
  logic                       wr_mis;
  logic [NRD-1:0]             rd_mis;

  fpx_wr_shape #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) wr_shape_i (
    .valid    (wr_valid),
    .idx      (wr_idx),
    .fmt      (wr_fmt),
    .data     (wr_data),
    .we       (we),
    .take_hi  (take_hi),
    .lo_word  (lo_word),
    .hi_word  (hi_word),
    .misalign (wr_mis)
  );

  // Both halves of a pair share this single edge, so a pair never tears.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      file_q <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (we[r]) file_q[r] <= take_hi[r] ? hi_word : lo_word;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    fpx_rd_port #(.NREGS(NREGS), .XLEN(XLEN), .IDXW(IDXW)) rd_port_i (
      .file_q   (file_q),
      .valid    (rd_valid[p]),
      .idx      (rd_idx[p]),
      .fmt      (rd_fmt[p]),
      .data     (rd_data[p]),
      .misalign (rd_mis[p])
    );
  end

  fpx_flag_reg #(.NFLAG(NRD + 1)) flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_d ({wr_mis, rd_mis}),
    .flag_q (misalign_q)
  );

endmodule

// File: rtl/fpx_regfile_chk.sv
module fpx_regfile_chk #(
  parameter int  NREGS = 32,
  parameter int  XLEN  = 32,
  parameter int  NRD   = 3,
  localparam int IDXW  = $clog2(NREGS),
  localparam int DW    = 2 * XLEN
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_valid,
  input logic [IDXW-1:0]          wr_idx,
  input logic [1:0]               wr_fmt,
  input logic [DW-1:0]            wr_data,
  input logic [NRD-1:0]           rd_valid,
  input logic [NRD-1:0][IDXW-1:0] rd_idx,
  input logic [NRD-1:0][1:0]      rd_fmt,
  input logic [NRD-1:0][DW-1:0]   rd_data,
  input logic [NRD:0]             misalign_q
);

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assert_x0_pair_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fmt[p] == 2'd2 && rd_idx[p] == '0) |-> rd_data[p] == '0);

    assert_half_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fmt[p] == 2'd0) |-> rd_data[p][DW-1:16] == '0);

    assert_odd_pair_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fmt[p] == 2'd2 && rd_idx[p][0]) |-> rd_data[p] == '0);

    assert_rd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[p] && rd_fmt[p] == 2'd2 && rd_idx[p][0]) |=> misalign_q[p]);
  end

  assert_wr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_fmt == 2'd2 && wr_idx[0]) |=> misalign_q[NRD]);

  assert_wr_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_fmt == 2'd2 && wr_idx[0]) |=> !misalign_q[NRD]);

  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid) && $past(wr_fmt) == 2'd1 && $past(wr_idx) != '0
     && rd_fmt[0] == 2'd1 && rd_idx[0] == $past(wr_idx))
    |-> rd_data[0][XLEN-1:0] == $past(wr_data[XLEN-1:0]));

  assert_half_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_valid) && $past(wr_fmt) == 2'd0 && $past(wr_idx) != '0
     && rd_fmt[0] == 2'd1 && rd_idx[0] == $past(wr_idx))
    |-> rd_data[0][XLEN-1:0] == {{(XLEN-16){$past(wr_data[15])}}, $past(wr_data[15:0])});

endmodule

bind fpx_regfile fpx_regfile_chk #(.NREGS(NREGS), .XLEN(XLEN), .NRD(NRD)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_idx     (wr_idx),
  .wr_fmt     (wr_fmt),
  .wr_data    (wr_data),
  .rd_valid   (rd_valid),
  .rd_idx     (rd_idx),
  .rd_fmt     (rd_fmt),
  .rd_data    (rd_data),
  .misalign_q (misalign_q)
);

// File: tb/fpx_regfile_tb_top.sv
`timescale 1ns/1ps
module fpx_regfile_tb_top;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_valid = 1'b0;
  logic [4:0]      wr_idx = '0;
  logic [1:0]      wr_fmt = '0;
  logic [63:0]     wr_data = '0;
  logic [2:0]      rd_valid = '0;
  logic [2:0][4:0] rd_idx = '0;
  logic [2:0][1:0] rd_fmt = '0;
  logic [2:0][63:0] rd_data;
  logic [3:0]      misalign_q;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] m [32];
  logic [3:0]  flag_exp = '0;

  always #2 clk = ~clk;

  fpx_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_fmt(wr_fmt), .wr_data(wr_data), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_fmt(rd_fmt), .rd_data(rd_data), .misalign_q(misalign_q)
  );

  function automatic logic [63:0] exp_rd(input logic [4:0] i, input logic [1:0] f);
    if (f == 2'd2) return (i == 0 || i[0]) ? 64'd0 : {m[i + 5'd1], m[i]};
    if (f == 2'd0) return {48'd0, m[i][15:0]};
    return {32'd0, m[i]};
  endfunction

  function automatic string rd_tag(input logic [4:0] i, input logic [1:0] f);
    if (f == 2'd2) return (i == 0) ? "R7" : (i[0] ? "R8" : "R5");
    if (f == 2'd0) return "R4";
    return "R2";
  endfunction

  task automatic model_write(input logic v, input logic [4:0] i, input logic [1:0] f,
                             input logic [63:0] d);
    if (!v || i == 0) return;
    if (f == 2'd2) begin
      if (!i[0]) begin
        m[i] = d[31:0];
        m[i + 5'd1] = d[63:32];
      end
    end else if (f == 2'd0) begin
      m[i] = {{16{d[15]}}, d[15:0]};
    end else begin
      m[i] = d[31:0];
    end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic wv, input logic [4:0] wi, input logic [1:0] wf,
                     input logic [63:0] wd, input logic [2:0] rv,
                     input logic [2:0][4:0] ri, input logic [2:0][1:0] rf,
                     input string tag);
    logic [3:0] nf;
    @(negedge clk);
    wr_valid = wv; wr_idx = wi; wr_fmt = wf; wr_data = wd;
    rd_valid = rv; rd_idx = ri; rd_fmt = rf;
    #1;
    for (int p = 0; p < 3; p++) begin
      logic [63:0] e;
      e = exp_rd(ri[p], rf[p]);
      chk(rd_data[p] == e, (tag != "") ? tag : rd_tag(ri[p], rf[p]), rd_data[p], e);
    end
    chk(misalign_q == flag_exp, (flag_exp != 0) ? "R8" : "R10",
        {60'd0, misalign_q}, {60'd0, flag_exp});
    for (int p = 0; p < 3; p++) nf[p] = rv[p] && rf[p] == 2'd2 && ri[p][0];
    nf[3] = wv && wf == 2'd2 && wi[0];
    flag_exp = nf;
    model_write(wv, wi, wf, wd);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int r = 0; r < 32; r++) m[r] = '0;
    rd_idx = {5'd7, 5'd6, 5'd5};
    rd_fmt = {2'd0, 2'd2, 2'd1};
    rd_valid = 3'b111;
    #9;
    // R1: reset state
    for (int p = 0; p < 3; p++) chk(rd_data[p] == 64'd0, "R1", rd_data[p], 64'd0);
    chk(misalign_q == 4'd0, "R1", {60'd0, misalign_q}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: half write with junk in upper data bits
    cyc(1'b1, 5'd3, 2'd0, 64'hDEAD_BEEF_1234_8001, 3'b000, '0, '0, "");
    cyc(1'b0, 5'd0, 2'd1, '0, 3'b000, {5'd3, 5'd3, 5'd3}, {2'd1, 2'd3, 2'd1}, "R3");
    // R2: single write ignores upper half
    cyc(1'b1, 5'd1, 2'd1, 64'hFFFF_FFFF_A5A5_A5A5, 3'b000, '0, '0, "");
    // R6: pair write, then both halves read individually and as a pair
    cyc(1'b1, 5'd10, 2'd2, 64'h1111_2222_3333_4444, 3'b000, {5'd1, 5'd1, 5'd1},
        {2'd1, 2'd1, 2'd1}, "R2");
    cyc(1'b0, 5'd0, 2'd0, '0, 3'b000, {5'd11, 5'd10, 5'd10},
        {2'd1, 2'd1, 2'd2}, "R6");
    // R7: pair write to x0 leaves x1 alone
    cyc(1'b1, 5'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 3'b000, '0, '0, "");
    cyc(1'b0, 5'd0, 2'd0, '0, 3'b000, {5'd0, 5'd1, 5'd0}, {2'd2, 2'd1, 2'd1}, "R7");
    // R8: odd pair write and reads, flagged next cycle
    cyc(1'b1, 5'd5, 2'd2, 64'h0BAD_0BAD_0BAD_0BAD, 3'b101, {5'd7, 5'd4, 5'd5},
        {2'd2, 2'd2, 2'd2}, "R8");
    cyc(1'b0, 5'd0, 2'd0, '0, 3'b000, {5'd6, 5'd5, 5'd4}, {2'd1, 2'd1, 2'd1}, "R8");
    // R9: read during write returns old value
    cyc(1'b1, 5'd12, 2'd1, 64'h0000_0000_CAFE_F00D, 3'b000, {5'd12, 5'd12, 5'd12},
        {2'd1, 2'd0, 2'd1}, "R9");
    // R11: held-off write changes nothing
    cyc(1'b0, 5'd12, 2'd1, 64'h0000_0000_1357_9BDF, 3'b000, '0, '0, "");
    cyc(1'b0, 5'd13, 2'd2, 64'h1, 3'b000, {5'd12, 5'd12, 5'd12},
        {2'd1, 2'd1, 2'd1}, "R11");

    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wi;
      logic [2:0][4:0] ri;
      logic [2:0][1:0] rf;
      wi = ($urandom % 4 == 0) ? 5'($urandom % 4) : 5'($urandom % 32);
      for (int p = 0; p < 3; p++) begin
        ri[p] = ($urandom % 4 == 0) ? 5'($urandom % 4) : 5'($urandom % 32);
        rf[p] = 2'($urandom % 4);
      end
      cyc(($urandom % 4) != 0, wi, 2'($urandom % 4), {$urandom, $urandom},
          3'($urandom % 8), ri, rf, "");
    end
    cyc(1'b0, 5'd0, 2'd0, '0, 3'b000, '0, '0, "");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule